// File: doc/BRIEF.md
# Pipelined TCP Transmit Client

This block sits on the user side of a hardware TCP engine and pushes a programmed number of equal-length packets over one established session. A one-cycle `start` pulse latches the session number, the packet length and the packet count. For every packet the block first asks the engine for permission with a request carrying the session and byte length. It waits for the status reply that belongs to that request. It then streams the payload as 64-byte beats, with a byte-enable mask and an end-of-packet flag, but only when the reply carries no error.

The handshake with the engine takes tens of cycles, while a full-size packet only takes about twenty beats to stream. To keep the payload bus busy, the block keeps issuing requests for later packets while the current payload is still going out. Up to eight requests can be outstanding, and they are tracked in an in-order queue. A rejected packet is not streamed. Its request is issued again later, and a retry counter records each rejection. The space value carried by the most recent reply is kept for the user to read. A done flag rises once the full count has gone out.

Top module: `tcptx_client`

## Requirements
- R1: Each request carries the latched session number and the latched length. A programmed length above MAX_SEG (1408 bytes by default) is requested and sent as MAX_SEG.
- R2: Requests run ahead of the payload stream. The number of accepted requests whose status has not yet been accepted reaches 8 when the engine is slow to answer, and it never exceeds 8.
- R3: Statuses are accepted in request order. A status with error field zero is followed by exactly ceil(length/64) payload beats, with `pay_last` set only on the final beat.
- R4: A status with a nonzero error field produces no payload. That packet is requested again later, and `retry_count` goes up by one. `retry_count` is cleared by an accepted start.
- R5: `last_space` holds the space field of the most recently accepted status. It is 0 after reset.
- R6: Bit i of `pay_keep` enables byte i, which is `pay_data[8i+7:8i]`. All 64 bits are set on every beat but the last. On the last beat, bit i is set only when i < length mod 64, or all bits are set when the length is a multiple of 64.
- R7: Payload byte p of the k-th packet streamed since start (counting from 0) equals (k + p) mod 256. Disabled bytes are zero.
- R8: While `req_ready` is low, a pending request holds its valid, session and length. While `pay_ready` is low, a pending beat holds its valid, data, keep and last.
- R9: `done` rises once the programmed count of packets has been streamed and stays high until the next accepted start. A count of zero gives `done` with no request.
- R10: A start pulse while a run is active and not done is ignored. The latched session, length and count are unchanged.
- R11: After reset, `req_valid`, `pay_valid` and `done` are low, and `retry_count` and `last_space` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run |
| cfg_session | input | SESS_W | Session number for the run |
| cfg_len | input | LEN_W | Packet length in bytes (at least 1) |
| cfg_count | input | CNT_W | Number of packets to send |
| req_valid | output | 1 | Transmit request valid |
| req_ready | input | 1 | Engine accepts the request |
| req_session | output | SESS_W | Session number of the request |
| req_length | output | LEN_W | Byte length of the request |
| sts_valid | input | 1 | Status reply valid |
| sts_ready | output | 1 | Block accepts the status |
| sts_error | input | ERR_W | Error code, zero means go |
| sts_space | input | SPACE_W | Remaining transmit buffer space |
| pay_valid | output | 1 | Payload beat valid |
| pay_ready | input | 1 | Payload sink accepts the beat |
| pay_data | output | DATA_W | Payload bytes, byte 0 in the low bits |
| pay_keep | output | DATA_W/8 | Byte enables |
| pay_last | output | 1 | Final beat of a packet |
| done | output | 1 | Programmed count fully streamed |
| retry_count | output | CNT_W | Rejected statuses in this run |
| last_space | output | SPACE_W | Space field of the latest status |

## Verification
The assertions assume that the engine answers every accepted request with exactly one status, in request order. They also assume that the engine holds `sts_valid` and the status fields until `sts_ready` takes them, and that the programmed length is at least one byte. The bench models the engine with an in-order queue of reply times drawn 10 to 30 cycles after each request, so it never answers unasked or out of order. Ready lines and rejections are drawn from a seeded generator, and lengths are drawn from 1 upward, with directed cases at 1, 64, 1408 and above the segment limit.

// File: rtl/tcptx_pkg.sv
// Shared definitions for the pipelined TCP transmit client.
// Assumes nothing beyond being compiled before the modules that import it.
package tcptx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } stream_state_t;
endpackage

// File: rtl/tcptx_fifo.sv
// In-order queue of outstanding request lengths.
// Assumes push is never asserted while full and pop never while empty.
module tcptx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill;

    // store the pushed entry
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // pointer and fill-level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            fill <= fill + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout  = mem[rd_ptr];
    assign full  = (fill == CNT_W'(DEPTH));
    assign empty = (fill == '0);
endmodule

// File: rtl/tcptx_issuer.sv
// Request issuer: counts packets still to be requested and raises a request
// whenever one is owed and the outstanding queue has room.
// Assumes load is only pulsed while no request is outstanding.
module tcptx_issuer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             queue_full,
    input  logic             req_ready,
    input  logic             retry,
    output logic             req_valid,
    output logic             fire
);
    logic [CNT_W-1:0] owed;

    assign req_valid = active && (owed != '0) && !queue_full;
    assign fire      = req_valid && req_ready;

    // owed requests: loaded at start, down on issue, up on rejection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else if (load) begin
            owed <= load_cnt;
        end else begin
            owed <= owed - CNT_W'(fire) + CNT_W'(retry);
        end
    end
endmodule

// File: rtl/tcptx_streamer.sv
// Payload streamer: on launch, emits ceil(len/64) beats of the byte pattern
// (k + p) mod 256, masks trailing bytes on the last beat, counts packets sent.
// Assumes launch only while idle and a launch length of at least one byte.
module tcptx_streamer
    import tcptx_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              launch,
    input  logic [LEN_W-1:0]  launch_len,
    input  logic              pay_ready,
    output logic              busy,
    output logic              pay_valid,
    output logic [DATA_W-1:0] pay_data,
    output logic [DATA_W/BYTE_W-1:0] pay_keep,
    output logic              pay_last,
    output logic [CNT_W-1:0]  sent
);
    localparam int KEEP_W = DATA_W / BYTE_W;
    localparam int OFF_W  = $clog2(KEEP_W);

    stream_state_t    state;
    logic [LEN_W-1:0] beat, last_idx;
    logic [OFF_W-1:0] rem;
    logic [7:0]       base;

    assign busy      = (state == ST_SEND);
    assign pay_valid = busy;
    assign pay_last  = busy && (beat == last_idx);
    assign base      = sent[7:0] + 8'(beat << OFF_W);

    // beat sequencing and packet counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sent     <= '0;
            beat     <= '0;
            last_idx <= '0;
            rem      <= '0;
        end else if (clear) begin
            sent <= '0;
        end else begin
            case (state)
                ST_IDLE: if (launch) begin
                    state    <= ST_SEND;
                    beat     <= '0;
                    last_idx <= (launch_len - 1'b1) >> OFF_W;
                    rem      <= launch_len[OFF_W-1:0];
                end
                ST_SEND: if (pay_ready) begin
                    if (pay_last) begin
                        state <= ST_IDLE;
                        sent  <= sent + 1'b1;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // per-byte enable and pattern generation
    for (genvar b = 0; b < KEEP_W; b++) begin : g_byte
        logic en;
        assign en = !pay_last || (rem == '0) || (OFF_W'(b) < rem);
        assign pay_keep[b] = en;
        assign pay_data[BYTE_W*b +: BYTE_W] = en ? (base + 8'(b)) : 8'h00;
    end
endmodule

// File: rtl/tcptx_client.sv
// Pipelined TCP transmit client top: latches a run on start, issues requests
// ahead of the payload, gates each payload on its in-order status, retries
// rejected packets and raises done after the programmed count.
// Assumes the engine answers every request once, in order, holding its status
// until accepted, and that cfg_len is at least one.
module tcptx_client
    import tcptx_pkg::*;
#(
    parameter int SESS_W  = 16,
    parameter int LEN_W   = 16,
    parameter int CNT_W   = 16,
    parameter int ERR_W   = 2,
    parameter int SPACE_W = 32,
    parameter int DATA_W  = 512,
    parameter int DEPTH   = 8,
    parameter int MAX_SEG = 1408
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [SESS_W-1:0]        cfg_session,
    input  logic [LEN_W-1:0]         cfg_len,
    input  logic [CNT_W-1:0]         cfg_count,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [SESS_W-1:0]        req_session,
    output logic [LEN_W-1:0]         req_length,
    input  logic                     sts_valid,
    output logic                     sts_ready,
    input  logic [ERR_W-1:0]         sts_error,
    input  logic [SPACE_W-1:0]       sts_space,
    output logic                     pay_valid,
    input  logic                     pay_ready,
    output logic [DATA_W-1:0]        pay_data,
    output logic [DATA_W/BYTE_W-1:0] pay_keep,
    output logic                     pay_last,
    output logic                     done,
    output logic [CNT_W-1:0]         retry_count,
    output logic [SPACE_W-1:0]       last_space
);
    logic              run, done_q, start_ok;
    logic [SESS_W-1:0] sess_q;
    logic [LEN_W-1:0]  len_q, len_eff, head_len;
    logic [CNT_W-1:0]  cnt_q, sent;
    logic [CNT_W-1:0]  retry_q;
    logic [SPACE_W-1:0] space_q;
    logic              q_full, q_empty, req_fire, busy;
    logic              sts_fire, sts_bad, launch;

    assign start_ok = start && (!run || done_q);
    assign len_eff  = (cfg_len > LEN_W'(MAX_SEG)) ? LEN_W'(MAX_SEG) : cfg_len;

    assign sts_ready = run && !busy && !q_empty;
    assign sts_fire  = sts_valid && sts_ready;
    assign sts_bad   = sts_fire && (sts_error != '0);
    assign launch    = sts_fire && (sts_error == '0);

    assign req_session = sess_q;
    assign req_length  = len_q;
    assign done        = done_q;
    assign retry_count = retry_q;
    assign last_space  = space_q;

    // run control and configuration latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            done_q <= 1'b0;
            sess_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else if (start_ok) begin
            run    <= 1'b1;
            done_q <= 1'b0;
            sess_q <= cfg_session;
            len_q  <= len_eff;
            cnt_q  <= cfg_count;
        end else if (run && (sent == cnt_q)) begin
            done_q <= 1'b1;
        end
    end

    // rejection counter and latest space report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q <= '0;
            space_q <= '0;
        end else begin
            if (start_ok)     retry_q <= '0;
            else if (sts_bad) retry_q <= retry_q + 1'b1;
            if (sts_fire)     space_q <= sts_space;
        end
    end

    tcptx_issuer #(.CNT_W(CNT_W)) u_issuer (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (run && !done_q),
        .load       (start_ok),
        .load_cnt   (cfg_count),
        .queue_full (q_full),
        .req_ready  (req_ready),
        .retry      (sts_bad),
        .req_valid  (req_valid),
        .fire       (req_fire)
    );

    tcptx_fifo #(.W(LEN_W), .DEPTH(DEPTH)) u_pending (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (req_fire),
        .din   (len_q),
        .pop   (sts_fire),
        .dout  (head_len),
        .full  (q_full),
        .empty (q_empty)
    );

    tcptx_streamer #(.LEN_W(LEN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_stream (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_ok),
        .launch     (launch),
        .launch_len (head_len),
        .pay_ready  (pay_ready),
        .busy       (busy),
        .pay_valid  (pay_valid),
        .pay_data   (pay_data),
        .pay_keep   (pay_keep),
        .pay_last   (pay_last),
        .sent       (sent)
    );
endmodule

// File: rtl/tcptx_client_chk.sv
// Protocol checker for tcptx_client, attached by bind.
// Assumes the engine side behaves as described in the top module header.
module tcptx_client_chk #(
    parameter int SESS_W  = 16,
    parameter int LEN_W   = 16,
    parameter int ERR_W   = 2,
    parameter int DATA_W  = 512,
    parameter int DEPTH   = 8,
    parameter int MAX_SEG = 1408
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SESS_W-1:0] req_session,
    input logic [LEN_W-1:0]  req_length,
    input logic              sts_valid,
    input logic              sts_ready,
    input logic [ERR_W-1:0]  sts_error,
    input logic              pay_valid,
    input logic              pay_ready,
    input logic [DATA_W-1:0] pay_data,
    input logic [DATA_W/8-1:0] pay_keep,
    input logic              pay_last,
    input logic              done
);
    localparam int OC_W = $clog2(DEPTH) + 2;
    logic [OC_W-1:0] outstanding;

    // outstanding requests as seen on the ports
    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= '0;
        else outstanding <= outstanding + OC_W'(req_valid && req_ready)
                                         - OC_W'(sts_valid && sts_ready);
    end

    // R2
    outstanding_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= OC_W'(DEPTH));

    // R3
    status_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ready |-> outstanding != '0);

    // R1
    length_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_length <= LEN_W'(MAX_SEG));

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_session) && $stable(req_length));

    // R8
    pay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid && !pay_ready |=> pay_valid && $stable(pay_data) && $stable(pay_keep)
                                    && $stable(pay_last));

    // R4
    reject_no_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid && sts_ready && (sts_error != '0) |=> !pay_valid);

    // R6
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid && !pay_last |-> &pay_keep);

    // R6
    last_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid && pay_last |-> pay_keep[0]);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid && !pay_valid);
endmodule

bind tcptx_client tcptx_client_chk #(
    .SESS_W(SESS_W), .LEN_W(LEN_W), .ERR_W(ERR_W), .DATA_W(DATA_W),
    .DEPTH(DEPTH), .MAX_SEG(MAX_SEG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_session(req_session), .req_length(req_length), .sts_valid(sts_valid),
    .sts_ready(sts_ready), .sts_error(sts_error), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .pay_data(pay_data), .pay_keep(pay_keep),
    .pay_last(pay_last), .done(done)
);

// File: tb/test_tcptx_client.sv
module test_tcptx_client;
    localparam int CLK_PERIOD = 10;
    localparam int MAXSEG     = 1408;

    logic         clk = 1'b0;
    logic         rst_n, start;
    logic [15:0]  cfg_session, cfg_len, cfg_count;
    logic         req_valid, req_ready;
    logic [15:0]  req_session, req_length;
    logic         sts_valid, sts_ready;
    logic [1:0]   sts_error;
    logic [31:0]  sts_space;
    logic         pay_valid, pay_ready, pay_last, done;
    logic [511:0] pay_data;
    logic [63:0]  pay_keep;
    logic [15:0]  retry_count;
    logic [31:0]  last_space;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcptx_client i_tcptx_client (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_session(cfg_session),
        .cfg_len(cfg_len), .cfg_count(cfg_count), .req_valid(req_valid),
        .req_ready(req_ready), .req_session(req_session), .req_length(req_length),
        .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_error(sts_error),
        .sts_space(sts_space), .pay_valid(pay_valid), .pay_ready(pay_ready),
        .pay_data(pay_data), .pay_keep(pay_keep), .pay_last(pay_last),
        .done(done), .retry_count(retry_count), .last_space(last_space)
    );

    int total = 0, bad = 0;
    int cyc = 0;
    int rdy_req = 100, rdy_pay = 100, err_pct = 0;
    int exp_len = 1, exp_sess = 0;
    int n_req, n_ok, n_err, n_pkts, outst, peak, exp_k, exp_beat;
    logic [31:0] exp_space = 0;
    int due_q[$];
    int last_due = 0;
    bit sts_taken = 0;
    bit pay_hold = 0;
    logic [511:0] prev_data;
    logic [63:0]  prev_keep;

    task automatic chk(bit ok, string req, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [511:0] exp_word(int k, int beat, int len);
        logic [511:0] w = '0;
        for (int b = 0; b < 64; b++) begin
            int p = beat * 64 + b;
            if (p < len) w[8*b +: 8] = 8'(k + p);
        end
        return w;
    endfunction

    function automatic logic [63:0] exp_keep(int beat, int len);
        logic [63:0] m = '0;
        for (int b = 0; b < 64; b++)
            if (beat * 64 + b < len) m[b] = 1'b1;
        return m;
    endfunction

    // engine model and port monitor
    initial begin
        req_ready = 0; sts_valid = 0; sts_error = 0; sts_space = 0; pay_ready = 0;
        forever begin
            @(negedge clk);
            cyc++;
            sts_taken = 0;
            if (rst_n) begin
                if (pay_hold) begin
                    chk(pay_valid == 1'b1, "R8 payload valid held", pay_valid, 1);
                    if (pay_data !== prev_data || pay_keep !== prev_keep)
                        chk(0, "R8 payload stable", 0, 1);
                end
                pay_hold  = pay_valid && !pay_ready;
                prev_data = pay_data;
                prev_keep = pay_keep;
                if (req_valid && req_ready) begin
                    int d;
                    n_req++;
                    if (req_session != 16'(exp_sess) || req_length != 16'(exp_len))
                        chk(0, "R1 request fields", req_length, exp_len);
                    d = cyc + 10 + $urandom_range(20);
                    if (d < last_due) d = last_due;
                    last_due = d;
                    due_q.push_back(d);
                    outst++;
                    if (outst > peak) peak = outst;
                end
                if (sts_valid && sts_ready) begin
                    sts_taken = 1;
                    outst--;
                    if (sts_error != 0) n_err++; else n_ok++;
                    exp_space = sts_space;
                end
                if (pay_valid && pay_ready) begin
                    logic [511:0] ew;
                    logic [63:0]  ek;
                    bit el;
                    ew = exp_word(exp_k, exp_beat, exp_len);
                    ek = exp_keep(exp_beat, exp_len);
                    el = (exp_beat == (exp_len - 1) / 64);
                    if (n_ok <= n_pkts) chk(0, "R4 payload without go status", n_ok, n_pkts + 1);
                    if (pay_keep !== ek) begin
                        total++; bad++;
                        $display("FAIL R6 keep actual=%h expected=%h", pay_keep, ek);
                    end
                    if (pay_data !== ew) begin
                        total++; bad++;
                        $display("FAIL R7 data actual=%h expected=%h", pay_data, ew);
                    end
                    if (pay_last !== el) chk(0, "R3 last beat", pay_last, el);
                    if (el) begin
                        exp_k++; exp_beat = 0; n_pkts++;
                    end else exp_beat++;
                end
            end
            @(posedge clk); #1;
            req_ready = ($urandom_range(99) < rdy_req);
            pay_ready = ($urandom_range(99) < rdy_pay);
            if (sts_taken) sts_valid = 0;
            if (!sts_valid && due_q.size() > 0 && due_q[0] <= cyc) begin
                void'(due_q.pop_front());
                sts_valid = 1;
                sts_error = ($urandom_range(99) < err_pct) ? 2'($urandom_range(3, 1)) : 2'd0;
                sts_space = $urandom;
            end
        end
    end

    task automatic run_case(int len, int cnt, int rq, int rp, int ep, bit poke);
        int t = 0;
        @(posedge clk); #1;
        cfg_session = 16'($urandom); cfg_len = 16'(len); cfg_count = 16'(cnt);
        rdy_req = rq; rdy_pay = rp; err_pct = ep;
        exp_len = (len > MAXSEG) ? MAXSEG : len;
        exp_sess = cfg_session;
        n_req = 0; n_ok = 0; n_err = 0; n_pkts = 0; outst = 0; peak = 0;
        exp_k = 0; exp_beat = 0;
        start = 1;
        @(posedge clk); #1 start = 0;
        if (poke) begin
            repeat (5) @(posedge clk);
            #1 cfg_count = 16'd3; cfg_session = ~cfg_session; cfg_len = 16'd7; start = 1;
            @(posedge clk); #1 start = 0;
        end
        while (!done && t < 60000) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R9 done raised", done, 1);
        chk(n_pkts == cnt, poke ? "R10 restart ignored count" : "R9 packets streamed", n_pkts, cnt);
        chk(n_ok == cnt, "R3 go statuses", n_ok, cnt);
        chk(int'(retry_count) == n_err, "R4 retry count", retry_count, n_err);
        chk(n_req == cnt + n_err, "R4 requests reissued", n_req, cnt + n_err);
        chk(last_space == exp_space, "R5 last space", last_space, exp_space);
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && !req_valid && !pay_valid, "R9 done held quiet", done, 1);
    endtask

    initial begin
        rst_n = 0; start = 0; cfg_session = 0; cfg_len = 1; cfg_count = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!req_valid && !pay_valid && !done, "R11 reset valids", {req_valid, pay_valid, done}, 0);
        chk(retry_count == 0 && last_space == 0, "R11 reset counters", retry_count, 0);
        @(posedge clk); #1 rst_n = 1;
        $urandom(32'd2024);

        // aligned full segment, engine always ready: queue fills to depth
        run_case(1408, 20, 100, 100, 0, 0);
        chk(peak == 8, "R2 outstanding peak", peak, 8);
        run_case(1, 5, 100, 100, 0, 0);          // single byte
        run_case(64, 6, 80, 60, 0, 0);           // one full beat
        run_case(100, 7, 100, 50, 0, 0);         // 36-byte tail
        run_case(2000, 4, 100, 100, 0, 0);       // clamped to segment limit
        run_case(300, 0, 100, 100, 0, 0);        // empty run
        chk(n_req == 0, "R9 zero count no request", n_req, 0);
        run_case(500, 10, 100, 100, 40, 0);      // rejections
        chk(n_err > 0, "R4 rejections exercised", n_err, 1);
        run_case(200, 6, 100, 100, 0, 1);        // start pulse mid-run
        for (int i = 0; i < 6; i++)
            run_case($urandom_range(1500, 1), $urandom_range(12, 1),
                     $urandom_range(100, 30), $urandom_range(100, 30), 20, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule